// File: doc/BRIEF.md
# ECC Flash Fault-Injection Control Registers

This block is the small register file that sits beside an ECC-protected flash array. It holds two registers and one flag. The test register has a single force bit. While that bit is set, every array read counts as a double-bit failure, so software can run its fault interrupt handler without a damaged array. The configuration register holds four enables. One of them is a key-access bit that can only be written while an external key-enable input is high.

The array path reports each read with a strobe and a double-bit-error indication. The block combines these with the force bit to set a sticky double-fault flag. Software clears the flag through a write-one-to-clear status register. The interrupt output is the flag masked by its enable.

The flag is tracked by a two-state machine. Its states are `FS_CLEAN` (no fault recorded) and `FS_FAULTED` (fault recorded).

- Transition "fault": `FS_CLEAN` goes to `FS_FAULTED` when a read strobe arrives with either the ECC error or the force bit set.
- Transition "acknowledge": `FS_FAULTED` goes to `FS_CLEAN` when software writes 1 to the flag position and no fault event arrives in the same cycle.
- In every other case the state holds.

Top module: `fdi_ctrl`

Register map (2-bit address, 8-bit data):

| Address | Register | Bits |
|---|---|---|
| 0 | test | bit 0 is the force bit |
| 1 | configuration | bit 0 buffer-empty interrupt enable, bit 1 command-complete interrupt enable, bit 2 key-access, bit 3 double-fault interrupt enable |
| 2 | status | bit 0 is the double-fault flag, write-one-to-clear |
| 3 | none | reads 0, ignores writes |

## Requirements
- R1: After reset, every address reads 0x00 and `irq_dbl` is 0.
- R2: Address 0 holds only bit 0, the force bit. Bits 7..1 always read 0. Writing 0 to bit 0 clears the force bit.
- R3: With the force bit at 0, a read strobe sets the double-fault flag (status bit 0) only if `arr_dbl_err` is 1 in that cycle. A read strobe with `arr_dbl_err` at 0 leaves the flag unchanged. `arr_dbl_err` without a read strobe also leaves the flag unchanged.
- R4: With the force bit at 1, every read strobe sets the flag, whatever the value of `arr_dbl_err`.
- R5: The flag is sticky. It clears only when software writes to address 2 with bit 0 equal to 1. Writing 0 to bit 0 of address 2 leaves the flag unchanged.
- R6: If a flag-setting read and a clearing write happen in the same cycle, the flag ends up set.
- R7: `irq_dbl` equals the flag AND configuration bit 3, combinationally. Changing the enable masks or unmasks a pending flag in the same cycle.
- R8: Configuration bits 0, 1 and 3 are read/write. Bits 7..4 always read 0.
- R9: A write to configuration bit 2 (key-access) takes effect only while `key_en` is 1. Otherwise the bit keeps its value.
- R10: A write becomes visible on the clock edge that samples `reg_wr`. Reads return the current contents combinationally. Address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data |
| key_en | input | 1 | Allows writes to the key-access bit |
| arr_rd | input | 1 | One strobe per array read |
| arr_dbl_err | input | 1 | Double-bit error reported for the current read |
| irq_dbl | output | 1 | Double-fault interrupt |

## Verification
The hardest case to reach from the ports is a collision: a flag-setting read and a write-one-to-clear landing on the same edge, starting from either flag state. The bench first places the flag in the wanted state, using a forced read when the flag must start set. It then loads the force bit for the test. Finally it applies every combination of read strobe, ECC error, force bit and clear action (none, write 0, write 1) in a single cycle. The resulting flag and interrupt are compared with values computed in the bench.

// File: rtl/fdi_pkg.sv
package fdi_pkg;

    // register addresses
    localparam int ADR_TEST = 0;
    localparam int ADR_CFG  = 1;
    localparam int ADR_STAT = 2;

    // bit positions
    localparam int BIT_FORCE = 0;
    localparam int BIT_BEIE  = 0;
    localparam int BIT_CCIE  = 1;
    localparam int BIT_KEY   = 2;
    localparam int BIT_DFIE  = 3;
    localparam int BIT_DFLAG = 0;

    typedef enum logic {
        FS_CLEAN,
        FS_FAULTED
    } flt_state_e;

    typedef struct packed {
        logic dfie;
        logic key;
        logic ccie;
        logic beie;
    } cfg_t;

endpackage

// File: rtl/fdi_regs.sv
module fdi_regs
    import fdi_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              key_en,
    output logic              force_q,
    output cfg_t              cfg_q
);

    logic hit_test;
    logic hit_cfg;

    always_comb begin
        hit_test = wr && (addr == ADDR_W'(ADR_TEST));
        hit_cfg  = wr && (addr == ADDR_W'(ADR_CFG));
    end

    // test register: only the force bit is stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_q <= 1'b0;
        end else if (hit_test) begin
            force_q <= wdata[BIT_FORCE];
        end
    end

    // configuration register; the key bit is gated by key_en
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (hit_cfg) begin
            cfg_q.beie <= wdata[BIT_BEIE];
            cfg_q.ccie <= wdata[BIT_CCIE];
            cfg_q.dfie <= wdata[BIT_DFIE];
            if (key_en) begin
                cfg_q.key <= wdata[BIT_KEY];
            end
        end
    end

endmodule

// File: rtl/fdi_fault_fsm.sv
module fdi_fault_fsm
    import fdi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arr_rd,
    input  logic arr_dbl_err,
    input  logic force_dfd,
    input  logic clr_req,
    output logic flag
);

    flt_state_e state_q;
    flt_state_e state_d;
    logic       fault_evt;

    always_comb begin
        fault_evt = arr_rd && (arr_dbl_err || force_dfd);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_CLEAN: begin
                if (fault_evt) begin
                    state_d = FS_FAULTED;            // fault
                end
            end
            FS_FAULTED: begin
                if (clr_req && !fault_evt) begin
                    state_d = FS_CLEAN;              // acknowledge; set wins
                end
            end
            default: state_d = FS_CLEAN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            FS_CLEAN:   flag = 1'b0;
            FS_FAULTED: flag = 1'b1;
            default:    flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/fdi_rdmux.sv
module fdi_rdmux
    import fdi_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              force_q,
    input  cfg_t              cfg_q,
    input  logic              flag,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADR_TEST)) begin
            rdata[BIT_FORCE] = force_q;
        end else if (addr == ADDR_W'(ADR_CFG)) begin
            rdata[BIT_BEIE] = cfg_q.beie;
            rdata[BIT_CCIE] = cfg_q.ccie;
            rdata[BIT_KEY]  = cfg_q.key;
            rdata[BIT_DFIE] = cfg_q.dfie;
        end else if (addr == ADDR_W'(ADR_STAT)) begin
            rdata[BIT_DFLAG] = flag;
        end
    end

endmodule

// File: rtl/fdi_ctrl.sv
module fdi_ctrl
    import fdi_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              key_en,
    input  logic              arr_rd,
    input  logic              arr_dbl_err,
    output logic              irq_dbl
);

    logic force_q;
    cfg_t cfg_q;
    logic flag;
    logic clr_req;

    always_comb begin
        clr_req = reg_wr && (reg_addr == ADDR_W'(ADR_STAT)) && reg_wdata[BIT_DFLAG];
        irq_dbl = flag && cfg_q.dfie;
    end

    fdi_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .key_en  (key_en),
        .force_q (force_q),
        .cfg_q   (cfg_q)
    );

    fdi_fault_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arr_rd      (arr_rd),
        .arr_dbl_err (arr_dbl_err),
        .force_dfd   (force_q),
        .clr_req     (clr_req),
        .flag        (flag)
    );

    fdi_rdmux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rdmux (
        .addr    (reg_addr),
        .force_q (force_q),
        .cfg_q   (cfg_q),
        .flag    (flag),
        .rdata   (reg_rdata)
    );

endmodule

// File: rtl/fdi_ctrl_chk.sv
module fdi_ctrl_chk
    import fdi_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              key_en,
    input logic              arr_rd,
    input logic              arr_dbl_err,
    input logic              irq_dbl,
    input logic              force_q,
    input cfg_t              cfg_q,
    input logic              flag
);

    logic wr_clear;

    always_comb begin
        wr_clear = reg_wr && (reg_addr == ADDR_W'(ADR_STAT)) && reg_wdata[BIT_DFLAG];
    end

    a_r3_ecc_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && arr_dbl_err) |=> flag);

    a_r3_quiet_keeps_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(arr_rd && (arr_dbl_err || force_q))) |=> !flag);

    a_r4_forced_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && force_q) |=> flag);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_clear) |=> flag);

    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && arr_rd && arr_dbl_err) |=> reg_addr != ADDR_W'(ADR_STAT) || reg_rdata[BIT_DFLAG]);

    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dbl |-> flag);

    a_r9_key_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !key_en |=> $stable(cfg_q.key));

    a_r2_test_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADR_TEST)) |-> (reg_rdata[DATA_W-1:1] == '0));

endmodule

bind fdi_ctrl fdi_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .key_en      (key_en),
    .arr_rd      (arr_rd),
    .arr_dbl_err (arr_dbl_err),
    .irq_dbl     (irq_dbl),
    .force_q     (force_q),
    .cfg_q       (cfg_q),
    .flag        (flag)
);

// File: tb/fdi_ctrl_test.sv
module fdi_ctrl_test;

    localparam int A_TEST = 0;
    localparam int A_CFG  = 1;
    localparam int A_STAT = 2;
    localparam int A_NONE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       key_en = 1'b0;
    logic       arr_rd = 1'b0;
    logic       arr_dbl_err = 1'b0;
    logic       irq_dbl;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fdi_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .key_en      (key_en),
        .arr_rd      (arr_rd),
        .arr_dbl_err (arr_dbl_err),
        .irq_dbl     (irq_dbl)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d, input logic k);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d); key_en = k;
        @(negedge clk);
        reg_wr = 1'b0; key_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 2'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic pulse_read(input logic err);
        @(negedge clk);
        arr_rd = 1'b1; arr_dbl_err = err;
        @(negedge clk);
        arr_rd = 1'b0; arr_dbl_err = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int v;
        int key_model;
        int cfg_exp;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            check("R1 reset read", v, 0);
        end
        check("R1 reset irq", int'(irq_dbl), 0);
        rst_n = 1'b1;

        // R2 / R10: sweep test register
        for (int d = 0; d < 256; d++) begin
            wr(A_TEST, d, 1'b0);
            rd(A_TEST, v);
            check("R2 test reg", v, d & 1);
        end
        wr(A_TEST, 0, 1'b0);
        rd(A_TEST, v);
        check("R2 write 0 clears force", v, 0);

        // R8 / R9: sweep configuration with key_en both ways
        key_model = 0;
        for (int k = 0; k < 2; k++) begin
            for (int d = 0; d < 256; d++) begin
                wr(A_CFG, d, k[0]);
                if (k == 1) key_model = (d >> 2) & 1;
                cfg_exp = (d & 'hB) | (key_model << 2);
                rd(A_CFG, v);
                check(k == 1 ? "R9 key written" : "R8/R9 cfg locked key", v, cfg_exp);
            end
        end

        // R10 address 3 ignores writes and reads 0
        wr(A_NONE, 'hFF, 1'b1);
        rd(A_NONE, v);
        check("R10 unused address", v, 0);

        // R10 write visible at the sampling edge
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'(A_TEST); reg_wdata = 8'h01;
        #1;
        check("R10 not before edge", int'(reg_rdata), 0);
        @(negedge clk);
        reg_wr = 1'b0;
        rd(A_TEST, v);
        check("R10 after edge", v, 1);
        wr(A_TEST, 0, 1'b0);

        // R3..R7 near-exhaustive collision sweep
        for (int init = 0; init < 2; init++)
        for (int f = 0; f < 2; f++)
        for (int r = 0; r < 2; r++)
        for (int e = 0; e < 2; e++)
        for (int c = 0; c < 3; c++)
        for (int ie = 0; ie < 2; ie++) begin
            int exp_flag;
            wr(A_STAT, 1, 1'b0);
            if (init == 1) begin
                wr(A_TEST, 1, 1'b0);
                pulse_read(1'b0);
            end
            wr(A_TEST, f, 1'b0);
            wr(A_CFG, ie << 3, 1'b0);
            @(negedge clk);
            arr_rd = r[0]; arr_dbl_err = e[0];
            if (c != 0) begin
                reg_wr = 1'b1; reg_addr = 2'(A_STAT); reg_wdata = (c == 2) ? 8'h01 : 8'hFE;
            end
            @(negedge clk);
            arr_rd = 1'b0; arr_dbl_err = 1'b0; reg_wr = 1'b0;
            exp_flag = ((r == 1) && (f == 1 || e == 1)) ? 1 : ((init == 1 && c != 2) ? 1 : 0);
            rd(A_STAT, v);
            if (r == 1 && (f == 1 || e == 1) && c == 2)
                check("R6 set wins", v, exp_flag);
            else if (f == 1)
                check("R4 forced read", v, exp_flag);
            else if (init == 1)
                check("R5 sticky / w1c", v, exp_flag);
            else
                check("R3 ecc read", v, exp_flag);
            check("R7 irq", int'(irq_dbl), exp_flag & ie);
            // R7 combinational unmask/mask
            if (exp_flag == 1) begin
                @(negedge clk);
                reg_wr = 1'b1; reg_addr = 2'(A_CFG); reg_wdata = 8'((1 - ie) << 3);
                @(negedge clk);
                reg_wr = 1'b0;
                #1;
                check("R7 enable toggled", int'(irq_dbl), 1 - ie);
            end
        end

        // R3 error without strobe
        wr(A_TEST, 0, 1'b0);
        wr(A_STAT, 1, 1'b0);
        @(negedge clk);
        arr_dbl_err = 1'b1;
        @(negedge clk);
        arr_dbl_err = 1'b0;
        rd(A_STAT, v);
        check("R3 error without strobe", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule